// File: doc/BRIEF.md
# Resonant Converter Gate-Drive Sequencer

This block produces the switch timing for a resonant push-pull high-voltage converter from one fast clock, which is expected to come from a frequency-trimmed oscillator. A single counter divides time into half-cycles of 77 clocks, so one full switching period is 154 clocks. The two push-pull switches take turns, one per half-cycle. Each switch releases one clock before its partner is allowed on.

In every half-cycle a pre-regulator pulse is placed around the resonant voltage peak. Its width in clocks equals the setpoint. Its leading edge is pushed back by a quarter of the unused clocks. A clamp switch fills the remainder of the half-cycle, with a one-clock gap on each side of the pulse.

The setpoint is captured only where a half-cycle begins, so a change made mid-cycle never cuts a pulse short. A one-clock strobe marks the first count of each half-cycle for neighbouring logic.

Top module: `resGateSeq`

## Requirements
- R1: A half-cycle lasts exactly 77 clocks, numbered 0 to 76, and the halves alternate between even and odd. `halfStart` is high exactly at count 0 of every half and low at all other times.
- R2: `driveA` is high at counts 0..75 of each even half, and `driveB` is high at counts 0..75 of each odd half. Both are low at count 76.
- R3: The two push-pull drives are never high together. After either drive is high, the other stays low for at least the following clock.
- R4: The captured level n is derived from the 7-bit setpoint. Values of 77 or more give 77, the value 76 gives 75, and every other value is used as is. `pwmGate` is high for exactly n clocks of each half-cycle and never high when n is 0.
- R5: The leading edge of the pulse falls at count d = floor((77 − n) / 4). The pulse therefore covers counts d to d + n − 1.
- R6: `clampGate` is never high at count 0 or count 76. For n = 0 it is high at counts 1..75. Otherwise it is high at the counts 1..75 that lie outside d − 1 .. d + n, so a clamp clock is never next to a pulse clock.
- R7: The setpoint is captured on the clock edge at which a half-cycle begins (count 76 going to count 0, or the restart after enable). Changes at any other time have no effect on that half's pulse or clamp.
- R8: When `enable` is low at a clock edge, all gate outputs and `halfStart` are low after that edge. On the first edge with `enable` high again, the sequence restarts at count 0 of an even half.
- R9: A synchronous `rst` forces all outputs low and the captured level to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the sequence when high |
| setpoint | input | 7 | Requested pulse width in clocks (0..77) |
| driveA | output | 1 | Push-pull switch, even half-cycles |
| driveB | output | 1 | Push-pull switch, odd half-cycles |
| pwmGate | output | 1 | Pre-regulator pulse |
| clampGate | output | 1 | Clamp switch, complement of the pulse with gaps |
| halfStart | output | 1 | One-clock strobe at count 0 of each half-cycle |

## Verification
The bench sweeps every setpoint from 0 to 80, so the 76-to-75 fold, the saturation above 77 and the empty pulse at 0 all show up. A wrong fold would give a 76-clock pulse that leaves no room for the gap. A missed n = 0 case would leave a two-clock hole in the clamp. Random setpoint changes land mid-half, and a design that captured them early would show a pulse that moves or shortens within the same half. Random enable drops check that the restart begins at count 0 of the even half with `driveA`, not wherever the counter stopped. They also check that the outputs fall on the very next clock.

// File: rtl/resGatePkg.sv
package resGatePkg;
  localparam int HALF_LEN_DEF = 77;
  localparam int CNT_W = $clog2(HALF_LEN_DEF + 1);

  typedef struct packed {
    logic run;
    logic loadSet;
    logic phase;
    logic [CNT_W-1:0] cnt;
  } ctrlStrb_t;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import resGatePkg::*;
#(
  parameter int HALF_LEN = HALF_LEN_DEF
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  output ctrlStrb_t strb,
  output logic      halfStart
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic phase;
  logic run;
  logic atLast;

  assign atLast = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      run   <= 1'b0;
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run) begin
      run   <= 1'b1;
      cnt   <= '0;
      phase <= 1'b0;
    end else if (atLast) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign strb.run     = run;
  assign strb.loadSet = enable && (!run || atLast);
  assign strb.phase   = phase;
  assign strb.cnt     = cnt;
  assign halfStart    = run && (cnt == '0);

  // R8
  disable_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !run);

  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    halfStart |=> !halfStart);

  // R1
  half_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && atLast && enable) |=> (cnt == '0) && (phase != $past(phase)));
endmodule

// File: rtl/gateDatapath.sv
module gateDatapath
  import resGatePkg::*;
#(
  parameter int HALF_LEN = HALF_LEN_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrb_t        strb,
  input  logic [CNT_W-1:0] setpoint,
  output logic [1:0]       ppDrive,
  output logic             pwmGate,
  output logic             clampGate
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_LEN - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(HALF_LEN);

  function automatic logic [CNT_W-1:0] mapSet(input logic [CNT_W-1:0] s);
    if (s >= FULL) return FULL;
    else if (s == LAST) return CNT_W'(HALF_LEN - 2);
    else return s;
  endfunction

  logic [CNT_W-1:0] nEff;
  logic [SUM_W-1:0] c, dly, pwmEnd;
  logic inPulse, outsideGap;

  always_ff @(posedge clk) begin
    if (rst) nEff <= '0;
    else if (strb.loadSet) nEff <= mapSet(setpoint);
  end

  assign c      = SUM_W'(strb.cnt);
  assign dly    = (SUM_W'(HALF_LEN) - SUM_W'(nEff)) >> 2;
  assign pwmEnd = dly + SUM_W'(nEff);

  assign inPulse    = (nEff != '0) && (c >= dly) && (c < pwmEnd);
  assign outsideGap = (nEff == '0) || ((c + SUM_W'(2)) <= dly) ||
                      (c >= (pwmEnd + SUM_W'(1)));

  assign pwmGate   = strb.run && inPulse;
  assign clampGate = strb.run && (strb.cnt != '0) && (strb.cnt != LAST) && outsideGap;

  for (genvar p = 0; p < 2; p++) begin : ppGen
    assign ppDrive[p] = strb.run && (strb.phase == 1'(p)) && (strb.cnt != LAST);
  end

  // R3
  pp_gap_a_chk: assert property (@(posedge clk) disable iff (rst)
    ppDrive[0] |=> !ppDrive[1]);
  // R3
  pp_gap_b_chk: assert property (@(posedge clk) disable iff (rst)
    ppDrive[1] |=> !ppDrive[0]);
  // R6
  pwm_clamp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    pwmGate |=> !clampGate);
  // R6
  clamp_pwm_gap_chk: assert property (@(posedge clk) disable iff (rst)
    clampGate |=> !pwmGate);
  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(pwmGate && clampGate));
  // R4
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    (nEff != LAST) && (nEff <= FULL));
  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(strb.loadSet) |-> $stable(nEff));
endmodule

// File: rtl/resGateSeq.sv
module resGateSeq
  import resGatePkg::*;
#(
  parameter int HALF_LEN = HALF_LEN_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] setpoint,
  output logic             driveA,
  output logic             driveB,
  output logic             pwmGate,
  output logic             clampGate,
  output logic             halfStart
);
  ctrlStrb_t strb;
  logic [1:0] ppDrive;

  seqCtrl #(.HALF_LEN(HALF_LEN)) ctrl_i (
    .clk(clk), .rst(rst), .enable(enable), .strb(strb), .halfStart(halfStart)
  );

  gateDatapath #(.HALF_LEN(HALF_LEN)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .setpoint(setpoint),
    .ppDrive(ppDrive), .pwmGate(pwmGate), .clampGate(clampGate)
  );

  assign driveA = ppDrive[0];
  assign driveB = ppDrive[1];
endmodule

// File: tb/resGateSeq_tb_top.sv
`timescale 1ns/1ps
module resGateSeq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [6:0] setpoint = '0;
  logic driveA, driveB, pwmGate, clampGate, halfStart;

  int checks = 0;
  int fails = 0;

  bit mRun = 0, mPh = 0;
  int mCnt = 0, mN = 0;

  always #2.5 clk = ~clk;

  resGateSeq dut_i (
    .clk(clk), .rst(rst), .enable(enable), .setpoint(setpoint),
    .driveA(driveA), .driveB(driveB), .pwmGate(pwmGate),
    .clampGate(clampGate), .halfStart(halfStart)
  );

  function automatic int mapLevel(int s);
    if (s >= 77) return 77;
    if (s == 76) return 75;
    return s;
  endfunction

  function automatic bit expPwm(int n, int c);
    int d = (77 - n) / 4;
    return (n != 0) && (c >= d) && (c <= d + n - 1);
  endfunction

  function automatic bit expClamp(int n, int c);
    int d = (77 - n) / 4;
    if (c == 0 || c == 76) return 0;
    if (n == 0) return 1;
    return (c < d - 1) || (c > d + n);
  endfunction

  task automatic chk(string tag, string name, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s cnt=%0d n=%0d got=%0b exp=%0b", tag, name, mCnt, mN, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) begin
      mRun = 0; mCnt = 0; mPh = 0; mN = 0;
    end else if (!enable) begin
      mRun = 0; mCnt = 0; mPh = 0;
    end else if (!mRun) begin
      mRun = 1; mCnt = 0; mPh = 0; mN = mapLevel(setpoint);
    end else if (mCnt == 76) begin
      mCnt = 0; mPh = ~mPh; mN = mapLevel(setpoint);
    end else begin
      mCnt++;
    end
    @(negedge clk);
    if (!mRun) begin
      // R8 R9: stopped or reset, everything low
      chk(rst ? "R9" : "R8", "driveA", driveA, 0);
      chk(rst ? "R9" : "R8", "driveB", driveB, 0);
      chk(rst ? "R9" : "R8", "pwmGate", pwmGate, 0);
      chk(rst ? "R9" : "R8", "clampGate", clampGate, 0);
      chk(rst ? "R9" : "R8", "halfStart", halfStart, 0);
    end else begin
      chk("R1", "halfStart", halfStart, mCnt == 0);
      chk("R2", "driveA", driveA, !mPh && mCnt != 76);
      chk("R2", "driveB", driveB, mPh && mCnt != 76);
      chk("R5", "pwmGate", pwmGate, expPwm(mN, mCnt));
      chk("R6", "clampGate", clampGate, expClamp(mN, mCnt));
      chk("R3", "ppOverlap", driveA && driveB, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int pwmCount;
    void'($urandom(32'd12345));
    repeat (3) step();
    rst = 1'b0;
    step();
    enable = 1'b1;
    // R4 sweep of every setpoint, including fold and saturation
    for (int s = 0; s <= 80; s++) begin
      setpoint = 7'(s);
      while (!(mRun && mCnt == 76)) step();
      pwmCount = 0;
      for (int k = 0; k < 77; k++) begin
        step();
        if (pwmGate) pwmCount++;
      end
      checks++;
      if (pwmCount != mapLevel(s)) begin
        fails++;
        $display("FAIL R4 width s=%0d got=%0d exp=%0d", s, pwmCount, mapLevel(s));
      end
    end
    // R7 directed: change mid-half must not move the current pulse
    setpoint = 7'd20;
    while (!(mRun && mCnt == 76)) step();
    step();
    setpoint = 7'd70;
    repeat (30) step();
    // R8 directed: drop enable mid-half, then restart
    enable = 1'b0;
    repeat (5) step();
    enable = 1'b1;
    step();
    chk("R8", "restartA", driveA, 1);
    chk("R8", "restartStrobe", halfStart, 1);
    // Random mix
    for (int i = 0; i < 40000; i++) begin
      if ($urandom_range(0, 19) == 0) setpoint = 7'($urandom_range(0, 127));
      if ($urandom_range(0, 599) == 0) enable = ~enable;
      if (!enable && $urandom_range(0, 7) == 0) enable = 1'b1;
      step();
    end
    // R9 reset mid-run
    rst = 1'b1;
    step();
    step();
    finish_run();
  end
endmodule